// File: doc/BRIEF.md
# Field Memory Power-Up Sequencer

This block brings a field delay memory, one with separate serial write and read ports, into a usable state after power is applied. The memory's address pointers hold no meaning at power-up. A fixed ritual makes them valid: wait for the supply to settle, clock each port a minimum number of times with no useful data, then pulse each port's pointer reset. The sequencer runs that ritual. It drives a clock-enable and a reset strobe for each port, and raises a done flag once both ports are ready. The `start` input stands for supply-good.

Both ports follow the same script in lockstep, so their strobes coincide. A `recover` input selects a longer script for the case where dummy cycles may have begun before the supply settled. In that script each port gets a reset, then the dummy run, then a second reset. Once done, the port controls come from user inputs. The sequencer still guarantees the minimum low time between reset strobes, so a user reset request that comes too early is held back until the gap has passed.

Top module: `fmi_init_seq`

## Requirements
- R1: No clock-enable or reset activity appears on either port until the settling interval has passed. The first activity is registered on the (STAB_CYCLES+1)th rising edge after `start` is applied, counting the first edge that samples it high as edge 1.
- R2: In the normal script each port gets exactly DUMMY_CYCLES consecutive cycles of clock-enable high. A single reset pulse follows on the very next cycle. Only one reset pulse per port occurs before done.
- R3: Both ports run the script in lockstep. Their clock-enables and reset strobes are high in the same cycles while done is low.
- R4: With `recover` high when the wait ends, each port gets a reset pulse first, then GAP_CYCLES low cycles, then DUMMY_CYCLES cycles of clock-enable, then a second reset pulse.
- R5: Every reset pulse is one cycle wide and is followed by at least GAP_CYCLES cycles low before the next. After done, a held user reset request gives one pulse every GAP_CYCLES+1 cycles.
- R6: `done` rises GAP_CYCLES+1 cycles after the final reset pulse of the script. It stays high while `start` stays high and is low on the cycle after `start` is sampled low.
- R7: The user clock-enable and reset-request inputs have no effect on the port outputs before done.
- R8: After done, each port clock-enable output follows its user clock-enable input with one cycle of latency.
- R9: Dropping `start` at any point returns both ports to idle, with all strobes low on the next cycle. Raising `start` again reruns the whole script.
- R10: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and both port strobes |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Supply-good; high starts the script, low aborts it |
| recover | input | 1 | Selects the reset–dummy–reset script |
| usr_wck_en | input | 1 | User write-clock enable, used after done |
| usr_wrst_req | input | 1 | User write-pointer reset request, used after done |
| usr_rck_en | input | 1 | User read-clock enable, used after done |
| usr_rrst_req | input | 1 | User read-pointer reset request, used after done |
| wck_en | output | 1 | Write-port clock enable |
| wrst | output | 1 | Write-pointer reset strobe |
| rck_en | output | 1 | Read-port clock enable |
| rrst | output | 1 | Read-pointer reset strobe |
| done | output | 1 | Both ports initialised |

## Verification
The bench builds the block with STAB_CYCLES = 40, DUMMY_CYCLES = 80 and GAP_CYCLES = 2. The short settling wait keeps every script to a few hundred cycles, so each script can be traced cycle by cycle and its exact done cycle checked. The real 80-cycle dummy minimum and the 2-cycle reset gap are kept, so the run-length and gap spacing are checked at their true values. Because of this, a held user reset request must give the 1-0-0 pulse pattern.

// File: rtl/fmi_pkg.sv
package fmi_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_WAIT,
    PS_DUMMY,
    PS_RESET,
    PS_GAP,
    PS_DONE
  } fmi_state_e;
endpackage

// File: rtl/fmi_stab_timer.sv
module fmi_stab_timer #(
  parameter int unsigned STAB_CYCLES = 12_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic stab_ok
);
  localparam int unsigned TW = $clog2(STAB_CYCLES + 1);

  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk) begin
    if (rst || !start) tcnt_q <= '0;
    else if (tcnt_q != TW'(STAB_CYCLES)) tcnt_q <= tcnt_q + 1'b1;
  end

  assign stab_ok = (tcnt_q == TW'(STAB_CYCLES));

  // R1: the settled flag never drops while supply-good stays high
  a_r1_ok_sticky: assert property (@(posedge clk) disable iff (rst)
    (stab_ok && start) |=> stab_ok);
endmodule

// File: rtl/fmi_port_seq.sv
module fmi_port_seq
  import fmi_pkg::*;
#(
  parameter int unsigned DUMMY_CYCLES = 80,
  parameter int unsigned GAP_CYCLES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stab_ok,
  input  logic recover,
  input  logic usr_ck_en,
  input  logic usr_rst_req,
  output logic ck_en,
  output logic rst_pulse,
  output logic seq_done
);
  localparam int unsigned MAXC = (DUMMY_CYCLES > GAP_CYCLES) ? DUMMY_CYCLES : GAP_CYCLES;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned GW   = $clog2(GAP_CYCLES + 1);
  localparam int unsigned DW   = $clog2(DUMMY_CYCLES + 1);

  fmi_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          final_q, final_d;
  logic          ck_q, ck_d;
  logic          rs_q, rs_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    final_d = final_q;
    ck_d    = 1'b0;
    rs_d    = 1'b0;
    if (!start) begin
      state_d = PS_IDLE;
      cnt_d   = '0;
      final_d = 1'b0;
    end else begin
      unique case (state_q)
        PS_IDLE: state_d = PS_WAIT;
        PS_WAIT: begin
          if (stab_ok) begin
            if (recover) begin
              state_d = PS_RESET;
              rs_d    = 1'b1;
              final_d = 1'b0;
            end else begin
              state_d = PS_DUMMY;
              cnt_d   = CW'(1);
              ck_d    = 1'b1;
              final_d = 1'b1;
            end
          end
        end
        PS_DUMMY: begin
          if (cnt_q == CW'(DUMMY_CYCLES)) begin
            state_d = PS_RESET;
            rs_d    = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
            ck_d  = 1'b1;
          end
        end
        PS_RESET: begin
          state_d = PS_GAP;
          cnt_d   = CW'(1);
        end
        PS_GAP: begin
          if (cnt_q == CW'(GAP_CYCLES)) begin
            if (final_q) begin
              state_d = PS_DONE;
            end else begin
              state_d = PS_DUMMY;
              cnt_d   = CW'(1);
              ck_d    = 1'b1;
              final_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PS_DONE: begin
          ck_d = usr_ck_en;
          if (usr_rst_req && cnt_q == CW'(GAP_CYCLES)) begin
            rs_d  = 1'b1;
            cnt_d = '0;
          end else if (cnt_q != CW'(GAP_CYCLES)) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: state_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      cnt_q   <= '0;
      final_q <= 1'b0;
      ck_q    <= 1'b0;
      rs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      final_q <= final_d;
      ck_q    <= ck_d;
      rs_q    <= rs_d;
    end
  end

  assign ck_en     = ck_q;
  assign rst_pulse = rs_q;
  assign seq_done  = (state_q == PS_DONE);

  // Checker counters: run of low reset cycles, run of enable cycles
  logic [GW-1:0] low_run_q;
  logic [DW-1:0] en_run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run_q <= GW'(GAP_CYCLES);
      en_run_q  <= '0;
    end else begin
      if (rs_q) low_run_q <= '0;
      else if (low_run_q != GW'(GAP_CYCLES)) low_run_q <= low_run_q + 1'b1;
      if (!ck_q) en_run_q <= '0;
      else if (en_run_q != DW'(DUMMY_CYCLES)) en_run_q <= en_run_q + 1'b1;
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rs_q |=> !rs_q);

  a_r5_gap_low: assert property (@(posedge clk) disable iff (rst)
    $rose(rs_q) |-> (low_run_q == GW'(GAP_CYCLES)));

  a_r2_dummy_run: assert property (@(posedge clk) disable iff (rst)
    ($fell(ck_q) && state_q == PS_RESET) |-> (en_run_q == DW'(DUMMY_CYCLES)));

  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!ck_q && !rs_q));
endmodule

// File: rtl/fmi_init_seq.sv
module fmi_init_seq #(
  parameter int unsigned STAB_CYCLES  = 12_500_000,
  parameter int unsigned DUMMY_CYCLES = 80,
  parameter int unsigned GAP_CYCLES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic recover,
  input  logic usr_wck_en,
  input  logic usr_wrst_req,
  input  logic usr_rck_en,
  input  logic usr_rrst_req,
  output logic wck_en,
  output logic wrst,
  output logic rck_en,
  output logic rrst,
  output logic done
);
  localparam int unsigned NPORT = 2;

  logic             stab_ok;
  logic [NPORT-1:0] usr_ck, usr_req, p_ck, p_rs, p_done;

  assign usr_ck  = {usr_rck_en, usr_wck_en};
  assign usr_req = {usr_rrst_req, usr_wrst_req};

  fmi_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stab_ok (stab_ok)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    fmi_port_seq #(
      .DUMMY_CYCLES (DUMMY_CYCLES),
      .GAP_CYCLES   (GAP_CYCLES)
    ) u_seq (
      .clk         (clk),
      .rst         (rst),
      .start       (start),
      .stab_ok     (stab_ok),
      .recover     (recover),
      .usr_ck_en   (usr_ck[p]),
      .usr_rst_req (usr_req[p]),
      .ck_en       (p_ck[p]),
      .rst_pulse   (p_rs[p]),
      .seq_done    (p_done[p])
    );
  end

  assign wck_en = p_ck[0];
  assign wrst   = p_rs[0];
  assign rck_en = p_ck[1];
  assign rrst   = p_rs[1];
  assign done   = &p_done;

  a_r6_done_drop: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);

  a_r1_no_early: assert property (@(posedge clk) disable iff (rst)
    ((wck_en || wrst || rck_en || rrst) && !done) |-> stab_ok);

  a_r3_lockstep: assert property (@(posedge clk) disable iff (rst)
    !done |-> (wrst == rrst && wck_en == rck_en));
endmodule

// File: tb/fmi_init_seq_bench.sv
module fmi_init_seq_bench;
  localparam int unsigned STAB  = 40;
  localparam int unsigned DUMMY = 80;
  localparam int unsigned GAP   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, recover = 1'b0;
  logic usr_wck_en = 1'b0, usr_wrst_req = 1'b0, usr_rck_en = 1'b0, usr_rrst_req = 1'b0;
  logic wck_en, wrst, rck_en, rrst, done;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  fmi_init_seq #(.STAB_CYCLES(STAB), .DUMMY_CYCLES(DUMMY), .GAP_CYCLES(GAP)) u_fmi_init_seq (
    .clk(clk), .rst(rst), .start(start), .recover(recover),
    .usr_wck_en(usr_wck_en), .usr_wrst_req(usr_wrst_req),
    .usr_rck_en(usr_rck_en), .usr_rrst_req(usr_rrst_req),
    .wck_en(wck_en), .wrst(wrst), .rck_en(rck_en), .rrst(rrst), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Scenario record
  int first_act, done_k, wen_cnt, ren_cnt, wruns, wrst_n, rrst_n, mism;
  int wrst_k[4];
  int first_en;

  task automatic run_script(input bit recov);
    bit prev_en;
    prev_en = 1'b0;
    first_act = 0; done_k = 0; wen_cnt = 0; ren_cnt = 0; wruns = 0;
    wrst_n = 0; rrst_n = 0; mism = 0; first_en = 0;
    recover = recov;
    // R7: user inputs held active during the script
    usr_wck_en = 1'b1; usr_rck_en = 1'b1; usr_wrst_req = 1'b1; usr_rrst_req = 1'b1;
    start = 1'b1;
    for (int k = 1; k < 1000; k++) begin
      tick();
      if (done) begin
        done_k = k;
        break;
      end
      if (first_act == 0 && (wck_en || wrst || rck_en || rrst)) first_act = k;
      if (first_en == 0 && wck_en) first_en = k;
      if (wck_en) wen_cnt++;
      if (rck_en) ren_cnt++;
      if (wck_en && !prev_en) wruns++;
      prev_en = wck_en;
      if (wrst) begin
        if (wrst_n < 4) wrst_k[wrst_n] = k;
        wrst_n++;
      end
      if (rrst) rrst_n++;
      if (wrst != rrst || wck_en != rck_en) mism++;
    end
    usr_wck_en = 1'b0; usr_rck_en = 1'b0; usr_wrst_req = 1'b0; usr_rrst_req = 1'b0;
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tick();
    chk(!wck_en && !wrst && !rck_en && !rrst && !done, "R10 outputs low after reset",
        {wck_en, wrst, rck_en, rrst, done}, 0);
  endtask

  task automatic t_normal();
    run_script(1'b0);
    chk(first_act == STAB + 1, "R1 first activity edge", first_act, STAB + 1);
    chk(wen_cnt == DUMMY, "R2 write dummy count", wen_cnt, DUMMY);
    chk(wruns == 1, "R2 dummy run contiguous", wruns, 1);
    chk(wrst_n == 1 && wrst_k[0] == STAB + 1 + DUMMY, "R2 reset right after dummy run",
        wrst_k[0], STAB + 1 + DUMMY);
    chk(ren_cnt == DUMMY && rrst_n == 1, "R3 read port matches", ren_cnt, DUMMY);
    chk(mism == 0, "R3 lockstep mismatches", mism, 0);
    chk(done_k == STAB + DUMMY + GAP + 2, "R6 done cycle", done_k, STAB + DUMMY + GAP + 2);
    chk(wrst_n == 1, "R7 user requests ignored before done", wrst_n, 1);
  endtask

  task automatic t_passthrough();
    usr_wck_en = 1'b1;
    tick();
    chk(wck_en == 1'b1 && rck_en == 1'b0, "R8 write enable follows user", wck_en, 1);
    usr_wck_en = 1'b0; usr_rck_en = 1'b1;
    tick();
    chk(wck_en == 1'b0 && rck_en == 1'b1, "R8 read enable follows user", rck_en, 1);
    usr_rck_en = 1'b0;
    tick();
    chk(done == 1'b1, "R6 done held while start high", done, 1);
  endtask

  task automatic t_gap();
    int bad;
    bad = 0;
    usr_wrst_req = 1'b1;
    for (int i = 0; i < 3 * (GAP + 1); i++) begin
      tick();
      if (wrst != ((i % (GAP + 1)) == 0)) bad++;
    end
    usr_wrst_req = 1'b0;
    chk(bad == 0, "R5 held request pulse spacing", bad, 0);
    tick(); tick();
    chk(wrst == 1'b0 && rrst == 1'b0, "R5 no pulse without request", wrst, 0);
  endtask

  task automatic t_drop_start();
    start = 1'b0;
    tick();
    chk(done == 1'b0, "R6 done falls after start low", done, 0);
    tick();
    chk(!wck_en && !wrst, "R9 idle after start low", {wck_en, wrst}, 0);
  endtask

  task automatic t_recovery();
    run_script(1'b1);
    chk(first_act == STAB + 1 && wrst_k[0] == STAB + 1, "R4 reset comes first", wrst_k[0], STAB + 1);
    chk(first_en == STAB + GAP + 2, "R4 dummy after gap", first_en, STAB + GAP + 2);
    chk(wrst_n == 2, "R4 two reset pulses", wrst_n, 2);
    chk(wrst_k[1] == STAB + GAP + DUMMY + 2, "R4 second reset cycle", wrst_k[1], STAB + GAP + DUMMY + 2);
    chk(wen_cnt == DUMMY && wruns == 1, "R4 dummy count", wen_cnt, DUMMY);
    chk(mism == 0 && rrst_n == 2, "R3 lockstep in recovery", mism, 0);
    chk(done_k == STAB + 2 * GAP + DUMMY + 3, "R6 recovery done cycle", done_k, STAB + 2 * GAP + DUMMY + 3);
    start = 1'b0;
    recover = 1'b0;
    tick(); tick();
  endtask

  task automatic t_abort();
    int en_seen;
    en_seen = 0;
    start = 1'b1;
    for (int k = 0; k < STAB + 20; k++) begin
      tick();
      if (wck_en) en_seen++;
    end
    chk(en_seen > 0, "R9 script running before abort", en_seen, 1);
    start = 1'b0;
    tick();
    chk(!wck_en && !rck_en && !wrst && !rrst && !done, "R9 abort clears outputs",
        {wck_en, rck_en, wrst, rrst, done}, 0);
    tick(); tick();
    run_script(1'b0);
    chk(first_act == STAB + 1 && done_k == STAB + DUMMY + GAP + 2, "R9 rerun after abort",
        done_k, STAB + DUMMY + GAP + 2);
    start = 1'b0;
    tick();
  endtask

  initial begin
    t_reset_state();
    t_normal();
    t_passthrough();
    t_gap();
    t_drop_start();
    t_recovery();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule